// File: doc/BRIEF.md
# Hardware-Triggered Nonvolatile Store Controller

This block is the control sequencer that sits beside a shadow-backed SRAM array. It turns chip enable, write enable and an active-low store request pin into one of four operating modes: deselected, read, write or store. It gates the array's enable, write strobe and output drive to match. It keeps a dirty flag that records whether the array has been written since the last nonvolatile cycle. It also sequences the copy of the array into the nonvolatile shadow.

A store request is first synchronized and filtered for a minimum pulse width. The block then raises an open-drain busy pull-down and an SRAM inhibit. It grants a grace window in which an access already under way may finish. If the array is dirty, it starts the transfer through a start/done handshake with the store engine, which is bounded by a maximum duration. If the array is clean, it skips the transfer. In both cases the array stays inhibited until the request pin returns high. A recovery interval is added only when a transfer actually took place. All durations are counted in clock cycles.

Top module: `nvstore_ctrl`

## Requirements
- R1: `mode` reports 0 when `ce_n` is high (deselect), 1 when `ce_n` is low and `we_n` is high (read), and 2 when both are low (write). While idle, a read or write raises `sram_en`, and a write also raises `sram_we`.
- R2: While the synchronized store pin is low, `mode` is 3 whatever `ce_n` and `we_n` are, and `dout_oe` stays low.
- R3: `oe_n` only gates `dout_oe` during a read. A store sequence starts with the same timing whatever `oe_n` is.
- R4: An accepted write (`sram_we` high at a clock edge) sets `dirty` from the next cycle. A read leaves `dirty` unchanged.
- R5: A store pin low pulse seen for fewer than MIN_PULSE_CYC synchronized cycles is ignored: `busy_pd` stays low and `dirty` is kept.
- R6: A falling edge of the store pin, driven just before a clock edge and held, raises `busy_pd` and `sram_inhibit` exactly MIN_PULSE_CYC+2 clock edges later, which must be within BUSY_LAT_CYC.
- R7: If `dirty` is low when the grace window ends, no `store_start` is issued. Once the pin returns high, busy clears 3 edges after the rise, with no recovery interval.
- R8: If `dirty` is high, `store_start` pulses for one cycle GRACE_CYC cycles after busy rises. A `store_done` pulse then ends the store and clears `dirty`.
- R9: With no `store_done`, the store ends after exactly STORE_CYC cycles and `dirty` clears at that edge.
- R10: After a store, every SRAM access is blocked (`sram_en` low) while the pin stays low. After the pin rises, busy holds for 3+RECOVER_CYC edges, with access still blocked.
- R11: A one-cycle `recall_done` clears `dirty`.
- R12: An access that is active when the request arrives keeps `sram_en` through the grace window for as long as `ce_n` stays low. A new access started inside the window is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| store_req_n | input | 1 | Asynchronous store request pin, active low |
| store_done | input | 1 | Store engine reports the transfer finished |
| recall_done | input | 1 | Recall engine reports shadow copied back |
| mode | output | 2 | Decoded mode: 0 deselect, 1 read, 2 write, 3 store |
| sram_en | output | 1 | Gated array enable |
| sram_we | output | 1 | Gated array write strobe |
| dout_oe | output | 1 | Data bus drive enable for reads |
| store_start | output | 1 | One-cycle request to the store engine |
| busy_pd | output | 1 | Open-drain busy pull-down enable |
| sram_inhibit | output | 1 | Array operations blocked |
| dirty | output | 1 | Array written since last nonvolatile cycle |

## Verification
The bench builds the block with MIN_PULSE_CYC=3, GRACE_CYC=6, STORE_CYC=40, RECOVER_CYC=5 and BUSY_LAT_CYC=8. With these values the filter boundary can be tested one cycle either side of the limit. The store timeout is reachable in a few dozen cycles, and the exact edges of busy rise, store start and recovery end can each be sampled on a single cycle. The grace window is long enough to end an in-flight write and then try a fresh access inside the same window.

// File: rtl/nvs_pkg.sv
// Package: shared state and mode encodings for the nonvolatile store controller.
// Assumes: nothing beyond standard SystemVerilog enums.
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRACE   = 3'd1,
        ST_STORE   = 3'd2,
        ST_INHIBIT = 3'd3,
        ST_RECOVER = 3'd4
    } nvs_state_e;

    typedef enum logic [1:0] {
        MODE_DESEL = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_STORE = 2'd3
    } nvs_mode_e;

endpackage

// File: rtl/nvs_req_filter.sv
// Module: two-flop synchronizer and minimum pulse-width qualifier for the
// active-low store request pin.
// Assumes: pin is asynchronous; MIN_PULSE_CYC >= 1. req_qual stays high while
// the synchronized pin has been low for at least MIN_PULSE_CYC cycles.
module nvs_req_filter #(
    parameter int MIN_PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req_low,
    output logic req_qual
);
    localparam int LC_W = (MIN_PULSE_CYC < 2) ? 1 : $clog2(MIN_PULSE_CYC + 1);
    localparam logic [LC_W-1:0] LC_TOP = LC_W'(MIN_PULSE_CYC - 1);

    logic       sync1_q;
    logic       sync2_q;
    logic [LC_W-1:0] low_cnt_q;

    // Purpose: resynchronize the pin and count consecutive low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q   <= 1'b1;
            sync2_q   <= 1'b1;
            low_cnt_q <= '0;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
            if (sync2_q) begin
                low_cnt_q <= '0;
            end else if (low_cnt_q != LC_TOP) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    // Purpose: expose synchronized level and qualified request.
    always_comb begin
        req_low  = ~sync2_q;
        req_qual = ~sync2_q && (low_cnt_q == LC_TOP);
    end

    AST_QUAL_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_qual |-> $past(~sync1_q)) else $error("qualified without low pin"); // R5

endmodule

// File: rtl/nvs_mode_decode.sv
// Module: combinational decode of chip enable, write enable and synchronized
// store level into the operating mode.
// Assumes: store_low is already synchronized; store has priority over all.
module nvs_mode_decode (
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             store_low,
    output nvs_pkg::nvs_mode_e mode
);
    import nvs_pkg::*;

    // Purpose: priority decode with store winning over chip selects.
    always_comb begin
        if (store_low) begin
            mode = MODE_STORE;
        end else if (ce_n) begin
            mode = MODE_DESEL;
        end else if (we_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_WRITE;
        end
    end

endmodule

// File: rtl/nvs_seq.sv
// Module: store sequencer FSM: idle, grace, store, inhibit, recover.
// Assumes: all *_CYC >= 1; store_done is a single-cycle pulse from the store
// engine; dirty is sampled on the last grace cycle to pick store or skip.
module nvs_seq #(
    parameter int GRACE_CYC   = 250,
    parameter int STORE_CYC   = 2500000,
    parameter int RECOVER_CYC = 175
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_qual,
    input  logic                req_low,
    input  logic                dirty,
    input  logic                store_done,
    output nvs_pkg::nvs_state_e state,
    output logic                store_start,
    output logic                store_end,
    output logic                busy
);
    import nvs_pkg::*;

    localparam int MAX_AB = (GRACE_CYC > RECOVER_CYC) ? GRACE_CYC : RECOVER_CYC;
    localparam int MAX_C  = (MAX_AB > STORE_CYC) ? MAX_AB : STORE_CYC;
    localparam int CW     = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] GRACE_TOP   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_TOP   = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RECOVER_TOP = CW'(RECOVER_CYC - 1);

    nvs_state_e      state_q;
    nvs_state_e      state_d;
    logic [CW-1:0]   cnt_q;
    logic            stored_q;

    // Purpose: next-state decision for the store sequence.
    always_comb begin
        state_d   = state_q;
        store_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_qual) state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (cnt_q == GRACE_TOP) state_d = dirty ? ST_STORE : ST_INHIBIT;
            end
            ST_STORE: begin
                if (store_done || (cnt_q == STORE_TOP)) begin
                    store_end = 1'b1;
                    state_d   = ST_INHIBIT;
                end
            end
            ST_INHIBIT: begin
                if (!req_low) state_d = stored_q ? ST_RECOVER : ST_IDLE;
            end
            ST_RECOVER: begin
                if (cnt_q == RECOVER_TOP) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state, per-state cycle counter and store-taken memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            stored_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q != ST_IDLE && state_q != ST_INHIBIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_STORE && state_d == ST_INHIBIT) begin
                stored_q <= 1'b1;
            end else if (state_q == ST_GRACE && state_d == ST_INHIBIT) begin
                stored_q <= 1'b0;
            end
        end
    end

    // Purpose: drive sequencer outputs from the registered state.
    always_comb begin
        state       = state_q;
        busy        = (state_q != ST_IDLE);
        store_start = (state_q == ST_STORE) && (cnt_q == '0);
    end

    AST_QUAL_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_qual) |=> busy) else $error("request not taken"); // R6

    AST_START_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE && cnt_q == GRACE_TOP && !dirty) |=> !store_start) else $error("store on clean array"); // R7

    AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STORE) |-> (cnt_q <= STORE_TOP)) else $error("store overran limit"); // R9

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INHIBIT && req_low) |=> (state_q == ST_INHIBIT)) else $error("inhibit left early"); // R10

endmodule

// File: rtl/nvs_access_gate.sv
// Module: gates array enable, write strobe and data drive by sequencer state.
// Assumes: a new access may only start in idle with no store request pending;
// an access already granted continues through idle and grace while ce_n low.
module nvs_access_gate (
    input  logic                clk,
    input  logic                rst_n,
    input  nvs_pkg::nvs_state_e state,
    input  logic                req_low,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    output logic                sram_en,
    output logic                sram_we,
    output logic                dout_oe
);
    import nvs_pkg::*;

    logic hold_q;
    logic allow_new;
    logic allow_hold;

    // Purpose: grant rules for new and in-flight accesses.
    always_comb begin
        allow_new  = (state == ST_IDLE) && !req_low;
        allow_hold = hold_q && (state == ST_IDLE || state == ST_GRACE);
        sram_en    = !ce_n && (allow_new || allow_hold);
        sram_we    = sram_en && !we_n;
        dout_oe    = !ce_n && we_n && !oe_n && allow_new;
    end

    // Purpose: remember that an access was granted so it may finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= sram_en;
        end
    end

    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE || state == ST_INHIBIT || state == ST_RECOVER) |-> !sram_en) else $error("access while inhibited"); // R10

    AST_GRACE_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && !ce_n && !$past(sram_en)) |-> !sram_en) else $error("new access in grace"); // R12

endmodule

// File: rtl/nvstore_ctrl.sv
// Module: top of the hardware-triggered nonvolatile store controller. Ties the
// request filter, mode decode, sequencer and access gate together and owns
// the dirty flag.
// Assumes: single clock; synchronous active-low reset; durations in cycles;
// BUSY_LAT_CYC >= MIN_PULSE_CYC + 2.
module nvstore_ctrl #(
    parameter int GRACE_CYC     = 250,
    parameter int STORE_CYC     = 2500000,
    parameter int RECOVER_CYC   = 175,
    parameter int MIN_PULSE_CYC = 4,
    parameter int BUSY_LAT_CYC  = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       store_req_n,
    input  logic       store_done,
    input  logic       recall_done,
    output logic [1:0] mode,
    output logic       sram_en,
    output logic       sram_we,
    output logic       dout_oe,
    output logic       store_start,
    output logic       busy_pd,
    output logic       sram_inhibit,
    output logic       dirty
);
    import nvs_pkg::*;

    localparam int LAT_W = $clog2(BUSY_LAT_CYC + 2);

    logic       req_low;
    logic       req_qual;
    logic       store_end;
    logic       busy;
    logic       dirty_q;
    nvs_mode_e  mode_w;
    nvs_state_e state;
    logic [LAT_W-1:0] lat_cnt_q;

    nvs_req_filter #(
        .MIN_PULSE_CYC (MIN_PULSE_CYC)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (store_req_n),
        .req_low  (req_low),
        .req_qual (req_qual)
    );

    nvs_mode_decode u_decode (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .store_low (req_low),
        .mode      (mode_w)
    );

    nvs_seq #(
        .GRACE_CYC   (GRACE_CYC),
        .STORE_CYC   (STORE_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_qual    (req_qual),
        .req_low     (req_low),
        .dirty       (dirty_q),
        .store_done  (store_done),
        .state       (state),
        .store_start (store_start),
        .store_end   (store_end),
        .busy        (busy)
    );

    nvs_access_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .req_low (req_low),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .sram_en (sram_en),
        .sram_we (sram_we),
        .dout_oe (dout_oe)
    );

    // Purpose: dirty flag; clears on store end or recall, a write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (sram_we) begin
            dirty_q <= 1'b1;
        end else if (store_end || recall_done) begin
            dirty_q <= 1'b0;
        end
    end

    // Purpose: measure cycles a synchronized request waits in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt_q <= '0;
        end else if (req_low && state == ST_IDLE) begin
            if (lat_cnt_q != LAT_W'(BUSY_LAT_CYC + 1)) lat_cnt_q <= lat_cnt_q + 1'b1;
        end else begin
            lat_cnt_q <= '0;
        end
    end

    // Purpose: drive top-level outputs.
    always_comb begin
        mode         = mode_w;
        busy_pd      = busy;
        sram_inhibit = busy;
        dirty        = dirty_q;
    end

    AST_BUSY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt_q < LAT_W'(BUSY_LAT_CYC)) else $error("busy latency exceeded"); // R6

    AST_STORE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_STORE) |-> !dout_oe) else $error("bus driven in store mode"); // R2

    AST_DIRTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_end && !sram_we) |=> !dirty_q) else $error("dirty kept after store"); // R8

    AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> dirty_q) else $error("write not recorded"); // R4

endmodule

// File: tb/nvstore_ctrl_tb.sv
module nvstore_ctrl_tb;

    localparam int MP = 3;
    localparam int GC = 6;
    localparam int SC = 40;
    localparam int RC = 5;
    localparam int BL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       store_req_n = 1'b1;
    logic       store_done = 1'b0;
    logic       recall_done = 1'b0;
    logic [1:0] mode;
    logic       sram_en, sram_we, dout_oe, store_start, busy_pd, sram_inhibit, dirty;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    nvstore_ctrl #(
        .GRACE_CYC(GC), .STORE_CYC(SC), .RECOVER_CYC(RC),
        .MIN_PULSE_CYC(MP), .BUSY_LAT_CYC(BL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .store_req_n(store_req_n), .store_done(store_done), .recall_done(recall_done),
        .mode(mode), .sram_en(sram_en), .sram_we(sram_we), .dout_oe(dout_oe),
        .store_start(store_start), .busy_pd(busy_pd), .sram_inhibit(sram_inhibit),
        .dirty(dirty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_write();
        ce_n = 1'b0; we_n = 1'b0;
        step(1);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("reset busy_pd", busy_pd, 0);
        chk("reset sram_inhibit", sram_inhibit, 0);
        chk("reset dirty", dirty, 0);
        chk("reset store_start", store_start, 0);
        chk("R1 reset mode deselect", mode, 0);
    endtask

    task automatic t_decode();
        ce_n = 1'b1; #1;
        chk("R1 deselect mode", mode, 0);
        chk("R1 deselect sram_en", sram_en, 0);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; #1;
        chk("R1 read mode", mode, 1);
        chk("R1 read sram_en", sram_en, 1);
        chk("R3 read dout_oe with oe low", dout_oe, 1);
        oe_n = 1'b1; #1;
        chk("R3 read dout_oe with oe high", dout_oe, 0);
        step(1);
        chk("R4 read leaves dirty", dirty, 0);
        we_n = 1'b0; #1;
        chk("R1 write mode", mode, 2);
        chk("R1 write sram_we", sram_we, 1);
        step(1);
        ce_n = 1'b1; we_n = 1'b1;
        chk("R4 write sets dirty", dirty, 1);
    endtask

    task automatic t_short();
        int seen = 0;
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        store_req_n = 1'b0;
        step(MP - 1);
        store_req_n = 1'b1;
        step(1);
        chk("R2 store mode while pin low", mode, 3);
        chk("R2 no data drive in store mode", dout_oe, 0);
        for (int i = 0; i < 10; i++) begin
            if (busy_pd) seen++;
            step(1);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        chk("R5 short pulse no busy", seen, 0);
        chk("R5 short pulse keeps dirty", dirty, 1);
    endtask

    task automatic t_store_dirty();
        oe_n = 1'b0;
        store_req_n = 1'b0;
        step(MP + 1);
        chk("R6 busy not yet", busy_pd, 0);
        step(1);
        chk("R6 busy at latency", busy_pd, 1);
        chk("R6 inhibit at latency", sram_inhibit, 1);
        step(GC - 1);
        chk("R8 no start before grace end", store_start, 0);
        step(1);
        chk("R8 store_start after grace", store_start, 1);
        step(3);
        store_done = 1'b1;
        step(1);
        store_done = 1'b0;
        chk("R8 dirty cleared by done", dirty, 0);
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R10 write blocked while inhibited", sram_en, 0);
        step(4);
        ce_n = 1'b1; we_n = 1'b1;
        chk("R10 blocked write leaves dirty", dirty, 0);
        chk("R10 inhibit held while pin low", busy_pd, 1);
        store_req_n = 1'b1;
        step(2);
        ce_n = 1'b0; #1;
        chk("R10 access blocked in recovery", sram_en, 0);
        ce_n = 1'b1;
        step(RC);
        chk("R10 busy through recovery", busy_pd, 1);
        step(1);
        chk("R10 busy ends after recovery", busy_pd, 0);
        oe_n = 1'b1;
    endtask

    task automatic t_store_clean();
        int starts = 0;
        store_req_n = 1'b0;
        step(MP + 2);
        chk("R7 busy on clean request", busy_pd, 1);
        for (int i = 0; i < GC + 5; i++) begin
            if (store_start) starts++;
            step(1);
        end
        chk("R7 no store on clean array", starts, 0);
        store_req_n = 1'b1;
        step(2);
        chk("R7 busy until pin seen high", busy_pd, 1);
        step(1);
        chk("R7 no recovery after skip", busy_pd, 0);
    endtask

    task automatic t_timeout();
        do_write();
        store_req_n = 1'b0;
        step(MP + 2 + GC);
        chk("R9 store started", store_start, 1);
        step(SC - 1);
        chk("R9 dirty held before limit", dirty, 1);
        step(1);
        chk("R9 store ends at limit", dirty, 0);
        store_req_n = 1'b1;
        step(RC + 5);
        chk("R9 idle after timeout sequence", busy_pd, 0);
    endtask

    task automatic t_recall();
        do_write();
        chk("R11 dirty before recall", dirty, 1);
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        chk("R11 recall clears dirty", dirty, 0);
    endtask

    task automatic t_grace();
        ce_n = 1'b0; we_n = 1'b0;
        store_req_n = 1'b0;
        step(MP + 2);
        chk("R12 busy raised", busy_pd, 1);
        chk("R12 in-flight write continues", sram_en, 1);
        chk("R12 in-flight strobe continues", sram_we, 1);
        ce_n = 1'b1;
        step(1);
        ce_n = 1'b0; #1;
        chk("R12 new access refused in grace", sram_en, 0);
        step(GC - 1);
        chk("R12 store follows grace", store_start, 1);
        chk("R12 access cut in store", sram_en, 0);
        ce_n = 1'b1; we_n = 1'b1;
        store_done = 1'b1;
        step(1);
        store_done = 1'b0;
        store_req_n = 1'b1;
        step(RC + 5);
        chk("R12 idle afterwards", busy_pd, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_decode();
        t_short();
        t_store_dirty();
        t_store_clean();
        t_timeout();
        t_recall();
        t_grace();
        step(2);
        finish_run();
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule